// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

The block multiplies two square matrices of unsigned 8-bit operands on a grid of N×N multiply-accumulate cells (N is 2 by default). Each cell keeps one element of the product C = A×B. Operands of A move one cell to the right on every clock, and operands of B move one cell down. On a start pulse the block captures both matrices, clears every accumulator and feeds the operands in. Row i of A is held back i cycles and column j of B is held back j cycles, so that cell (i,j) gets A[i][k] and B[k][j] in the same clock.

When the compute phase of 3N−2 cycles ends, the same rightward path carries the finished sums out. Each row shifts its accumulators to the right for N cycles. The row's rightmost cell drives that row's 16-bit result lane while a shared valid strobe is high. After the last result has left the grid, a one-cycle done pulse marks the end of the run.

Top module: `omm_array`

## Requirements
- R1: After reset, busy, done and res_valid are all low.
- R2: A start pulse seen while idle begins a run. busy is high from the next cycle for exactly 4N−2 cycles: 3N−2 compute cycles followed by N drain cycles.
- R3: Each result equals the unsigned sum over k of A[i][k]·B[k][j], reduced modulo 2^16. Element (r,c) of a matrix sits at bits [(r·N+c)·8 +: 8] of its input, and row i's result lane is res_row[i·16 +: 16].
- R4: The drain runs over N consecutive cycles. The first of them is the cycle 3N−2 cycles after the first busy cycle. In drain cycle d (0-based), lane i carries C[i][N−1−d], so the last column comes out first.
- R5: res_valid is high in the drain cycles and in no other cycle.
- R6: done is high for exactly one cycle, the cycle right after the last drain cycle. busy is low in that cycle.
- R7: A start pulse during a run has no effect on its timing or its results, and neither do changes to a_mat or b_mat after the start pulse.
- R8: Every run starts from cleared accumulators, so a run's results never include sums left over from an earlier run.
- R9: Accumulation wraps at 16 bits with no saturation. For N=2 with every operand 255, each result is 64514.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when the block is idle |
| a_mat | input | N*N*8 | Left matrix, row-major |
| b_mat | input | N*N*8 | Right matrix, row-major |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| res_valid | output | 1 | Result lanes carry data |
| res_row | output | N*16 | One result lane per row |

## Verification
The assertions assume that start is a clean synchronous level and that reset is held long enough to put the sequencer in idle. They do not constrain operand values, so any matrix content is legal. The stimulus drives start and the matrices half a cycle away from the sampling edge. It also raises start and rewrites both matrices during runs, on purpose, to test that these inputs are ignored. Besides random matrices, it covers zeros, all-255 operands that force the wrap, and identity matrices on either side of the product.

// File: rtl/omm_pkg.sv
package omm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_COMP  = 2'd1,
      ST_DRAIN = 2'd2
   } omm_state_e;
endpackage

// File: rtl/omm_pe.sv
module omm_pe #(
   parameter int DW = 8,
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          mac,
   input  logic          shift,
   input  logic [DW-1:0] a_in,
   input  logic [DW-1:0] b_in,
   input  logic [AW-1:0] acc_in,
   output logic [DW-1:0] a_out,
   output logic [DW-1:0] b_out,
   output logic [AW-1:0] acc_out
);
   localparam int PW = 2 * DW;

   logic [PW-1:0] prod;
   logic [AW-1:0] acc_q;

   assign prod    = a_in * b_in;
   assign acc_out = acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         a_out <= '0;
         b_out <= '0;
      end else begin
         a_out <= clr ? '0 : a_in;
         b_out <= clr ? '0 : b_in;
         if (clr)        acc_q <= '0;
         else if (shift) acc_q <= acc_in;
         else if (mac)   acc_q <= acc_q + AW'(prod);
      end
   end

   a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_q == '0));
   a_r7_hold_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !shift && !mac) |=> $stable(acc_q));
endmodule

// File: rtl/omm_feed.sv
module omm_feed #(
   parameter int N  = 2,
   parameter int DW = 8,
   parameter int CW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              run,
   input  logic [CW-1:0]     step,
   input  logic [N*N*DW-1:0] a_mat,
   input  logic [N*N*DW-1:0] b_mat,
   output logic [N*DW-1:0]   a_inj,
   output logic [N*DW-1:0]   b_inj
);
   logic [N*N*DW-1:0] a_hold, b_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_hold <= '0;
         b_hold <= '0;
      end else if (load) begin
         a_hold <= a_mat;
         b_hold <= b_mat;
      end
   end

   for (genvar l = 0; l < N; l++) begin : g_lane
      // lane l is delayed by l cycles: element index k = step - l
      always_comb begin
         int k;
         k = int'(step) - l;
         a_inj[l*DW +: DW] = '0;
         b_inj[l*DW +: DW] = '0;
         if (run && k >= 0 && k < N) begin
            a_inj[l*DW +: DW] = a_hold[(l*N + k)*DW +: DW];
            b_inj[l*DW +: DW] = b_hold[(k*N + l)*DW +: DW];
         end
      end
   end
endmodule

// File: rtl/omm_ctrl.sv
module omm_ctrl
   import omm_pkg::*;
#(
   parameter int N  = 2,
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          clr,
   output logic          run,
   output logic          shift,
   output logic          busy,
   output logic          done,
   output logic [CW-1:0] step
);
   localparam logic [CW-1:0] LAST_COMP  = CW'(3 * N - 3);
   localparam logic [CW-1:0] LAST_DRAIN = CW'(N - 1);

   omm_state_e st;

   assign clr   = (st == ST_IDLE) && start;
   assign run   = (st == ST_COMP);
   assign shift = (st == ST_DRAIN);
   assign busy  = (st != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         step <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: if (start) begin
               st   <= ST_COMP;
               step <= '0;
            end
            ST_COMP: if (step == LAST_COMP) begin
               st   <= ST_DRAIN;
               step <= '0;
            end else begin
               step <= step + 1'b1;
            end
            ST_DRAIN: if (step == LAST_DRAIN) begin
               st   <= ST_IDLE;
               step <= '0;
               done <= 1'b1;
            end else begin
               step <= step + 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r6_done_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(st) == ST_DRAIN && st == ST_IDLE));
   a_r7_step_advances: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_COMP && step != LAST_COMP) |=>
         (st == ST_COMP && step == CW'($past(step) + 1'b1)));
   a_r2_comp_to_drain: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_COMP && step == LAST_COMP) |=> (st == ST_DRAIN && step == '0));
endmodule

// File: rtl/omm_array.sv
module omm_array #(
   parameter int N  = 2,
   parameter int DW = 8,
   parameter int AW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [N*N*DW-1:0] a_mat,
   input  logic [N*N*DW-1:0] b_mat,
   output logic              busy,
   output logic              done,
   output logic              res_valid,
   output logic [N*AW-1:0]   res_row
);
   localparam int CW = $clog2(3 * N) + 1;

   if (N < 1)   begin : g_bad_n  $error("omm_array: N must be at least 1"); end
   if (N > 32)  begin : g_big_n  $error("omm_array: N above 32 is not supported"); end
   if (DW < 1)  begin : g_bad_dw $error("omm_array: DW must be at least 1"); end
   if (AW < DW) begin : g_bad_aw $error("omm_array: AW must be at least DW"); end

   logic          clr, run, shift;
   logic [CW-1:0] step;
   logic [N*DW-1:0] a_inj, b_inj;

   logic [DW-1:0] a_in  [N][N];
   logic [DW-1:0] b_in  [N][N];
   logic [DW-1:0] a_fwd [N][N];
   logic [DW-1:0] b_fwd [N][N];
   logic [AW-1:0] acc_l [N][N];
   logic [AW-1:0] acc_o [N][N];

   omm_ctrl #(.N(N), .CW(CW)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .start(start), .clr(clr), .run(run),
      .shift(shift), .busy(busy), .done(done), .step(step)
   );

   omm_feed #(.N(N), .DW(DW), .CW(CW)) feed_i (
      .clk(clk), .rst_n(rst_n), .load(clr), .run(run), .step(step),
      .a_mat(a_mat), .b_mat(b_mat), .a_inj(a_inj), .b_inj(b_inj)
   );

   for (genvar i = 0; i < N; i++) begin : g_row
      for (genvar j = 0; j < N; j++) begin : g_col
         if (j == 0) begin : g_left
            assign a_in[i][j]  = a_inj[i*DW +: DW];
            assign acc_l[i][j] = '0;
         end else begin : g_inner
            assign a_in[i][j]  = a_fwd[i][j-1];
            assign acc_l[i][j] = acc_o[i][j-1];
         end
         if (i == 0) begin : g_top
            assign b_in[i][j] = b_inj[j*DW +: DW];
         end else begin : g_below
            assign b_in[i][j] = b_fwd[i-1][j];
         end

         omm_pe #(.DW(DW), .AW(AW)) pe_i (
            .clk(clk), .rst_n(rst_n), .clr(clr), .mac(run), .shift(shift),
            .a_in(a_in[i][j]), .b_in(b_in[i][j]), .acc_in(acc_l[i][j]),
            .a_out(a_fwd[i][j]), .b_out(b_fwd[i][j]), .acc_out(acc_o[i][j])
         );
      end
      assign res_row[i*AW +: AW] = acc_o[i][N-1];
   end

   assign res_valid = shift;

   a_r5_valid_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> busy);
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !res_valid);
endmodule

// File: tb/omm_array_tb_top.sv
module omm_array_tb_top;
   localparam int N  = 2;
   localparam int DW = 8;
   localparam int AW = 16;
   localparam time CLK_PERIOD = 10ns;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [N*N*DW-1:0] a_mat = '0;
   logic [N*N*DW-1:0] b_mat = '0;
   logic              busy, done, res_valid;
   logic [N*AW-1:0]   res_row;

   int total = 0;
   int bad   = 0;

   logic [DW-1:0] ma [N][N];
   logic [DW-1:0] mb [N][N];

   always #(CLK_PERIOD / 2) clk = ~clk;

   omm_array #(.N(N), .DW(DW), .AW(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .a_mat(a_mat), .b_mat(b_mat),
      .busy(busy), .done(done), .res_valid(res_valid), .res_row(res_row)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [AW-1:0] ref_c(input int i, input int j);
      logic [31:0] s = 0;
      for (int k = 0; k < N; k++) s += 32'(ma[i][k]) * 32'(mb[k][j]);
      return s[AW-1:0];
   endfunction

   function automatic logic [N*N*DW-1:0] pack(input logic [DW-1:0] m [N][N]);
      logic [N*N*DW-1:0] v = '0;
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) v[(r*N+c)*DW +: DW] = m[r][c];
      return v;
   endfunction

   // one full run with checks; disturb=1 pokes start and the matrices mid-run (R7)
   task automatic do_run(input string tag, input bit disturb);
      @(negedge clk);
      a_mat = pack(ma);
      b_mat = pack(mb);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R2 busy after start", busy, 1);
      check("R5 no valid in compute", res_valid, 0);
      if (disturb) begin
         start = 1'b1;
         a_mat = ~a_mat;
         b_mat = {b_mat[0 +: DW], b_mat[N*N*DW-1:DW]} ^ 'h5a;
      end
      for (int t = 0; t < 3*N-2; t++) begin
         @(negedge clk);
         start = 1'b0;
      end
      for (int d = 0; d < N; d++) begin
         check("R4 R5 valid in drain", res_valid, 1);
         check("R2 busy in drain", busy, 1);
         for (int i = 0; i < N; i++)
            check($sformatf("R3 R4 %s lane %0d drain %0d", tag, i, d),
                  res_row[i*AW +: AW], ref_c(i, N-1-d));
         @(negedge clk);
      end
      check("R6 done pulse", done, 1);
      check("R6 busy low at done", busy, 0);
      check("R5 valid low after drain", res_valid, 0);
      @(negedge clk);
      check("R6 done single cycle", done, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 busy at reset", busy, 0);
      check("R1 done at reset", done, 0);
      check("R1 valid at reset", res_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", busy, 0);

      // zeros
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) begin ma[r][c] = '0; mb[r][c] = '0; end
      do_run("zeros", 0);

      // all 255: wraps (R9), expect 64514
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) begin ma[r][c] = 8'hff; mb[r][c] = 8'hff; end
      do_run("R9 wrap", 0);
      check("R9 wrap constant", ref_c(0, 0), 16'd64514);

      // identity on the left, then on the right; follows nonzero run (R8)
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) begin
            ma[r][c] = (r == c) ? 8'd1 : 8'd0;
            mb[r][c] = 8'(r * 17 + c * 41 + 3);
         end
      do_run("R8 identity left", 0);
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) begin
            ma[r][c] = 8'(r * 29 + c * 7 + 200);
            mb[r][c] = (r == c) ? 8'd1 : 8'd0;
         end
      do_run("identity right", 0);

      // one-hot sweep: each A element alone against a dense B
      for (int p = 0; p < N*N; p++) begin
         for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
               ma[r][c] = (r*N + c == p) ? 8'd255 : 8'd0;
               mb[r][c] = 8'(r * 64 + c * 16 + p + 1);
            end
         do_run("onehot", 0);
      end

      // random, some with mid-run disturbance (R7)
      for (int n = 0; n < 12; n++) begin
         for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
               ma[r][c] = 8'($urandom);
               mb[r][c] = 8'($urandom);
            end
         do_run("R7 random", n[0]);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule